// File: doc/BRIEF.md
# Receive Idle Timeout Detector

This block watches a receive FIFO and the character traffic through it, and tells the host when the stream has gone quiet. A countdown timer is reloaded whenever a character is written into the FIFO or read out of it. It then counts down on a slow tick input. When it runs out while the FIFO is empty and the feature is enabled, the block raises an exception request. The request carries a status code that marks it as a timeout. It stays raised until the host acknowledges it. Driver software uses this request to find the likely end of a block of data and to flush its buffers upward.

Only one timeout is reported per quiet period. Once a request has been posted, further expiries are swallowed until a new character is written into the FIFO. When the character just read out was an exception entry, such as a break or a parity error, the timer is stopped and does not restart on that read. No timeout follows that exception. The tick source, the FIFO storage and the host bus lie outside the block.

Top module: `rx_idle_timeout`

## Requirements
- R1: A timeout request is posted only when `fifo_empty` is 1 at the clock edge where the timer expires. An expiry while the FIFO holds data posts nothing.
- R2: A timeout request is posted only when `enable` is 1 at the expiry edge.
- R3: While `req` is 1, `req_status` equals 3'b100, the timeout code. While `req` is 0, `req_status` equals 3'b000.
- R4: After a timeout has been posted, later expiries post nothing until `wr_pulse` is seen. After that write, the next qualifying expiry posts again.
- R5: A read pulse with `rd_is_exc`=1 stops the timer, and no timeout follows that read unless a later write or normal read restarts the timer.
- R6: A write pulse or a read pulse loads the timer from `reload`. Each sampled `tick` then counts it down. The timer expires on tick number max(`reload`,1). `req` reads 1 in the cycle after the edge that sampled that tick. A new write or read before expiry restarts the full count.
- R7: Once raised, `req` stays 1 until an `ack` pulse is sampled. It reads 0 in the cycle after that pulse.
- R8: Driving `enable` to 0 clears a pending request at the next edge. The request does not come back when `enable` returns to 1.
- R9: Out of reset `req` and `req_status` are 0 and the timer is idle. Ticks with no character activity post nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Timer count strobe, one cycle wide |
| fifo_empty | input | 1 | 1 while the receive FIFO holds no entries |
| wr_pulse | input | 1 | One-cycle pulse per character written into the FIFO |
| rd_pulse | input | 1 | One-cycle pulse per character read from the FIFO |
| rd_is_exc | input | 1 | With `rd_pulse`: the character read was an exception entry |
| enable | input | 1 | Enables the timeout request |
| reload | input | CNT_W | Timer load value in ticks |
| ack | input | 1 | Acknowledge pulse for a pending request |
| req | output | 1 | Timeout exception request, held until acknowledged |
| req_status | output | STAT_W | Status code for the request (3'b100 = timeout) |

## Verification
The bench sweeps every reload value from 0 to 5. For each value it checks `req` after every single tick, which separates an off-by-one expiry from a correct one and shows how a zero reload is handled. It also tries all eight combinations of `enable`, `fifo_empty` at expiry and the exception flag on the last read. Only one of these combinations may raise a request. Further sequences cover these cases:
- a restart part way through the count;
- a second expiry in the same quiet period, which must stay silent until a write;
- a held request waiting for `ack`;
- a request removed by clearing `enable`.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int unsigned STAT_W      = 3;
  localparam logic [STAT_W-1:0] ST_NONE     = 3'b000;
  localparam logic [STAT_W-1:0] ST_IDLE_TMO = 3'b100;
endpackage

// File: rtl/idle_rst_sync.sv
module idle_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_pulse,
  input  logic             rd_pulse,
  input  logic             rd_is_exc,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             upd_en;
  logic             last_step;

  assign last_step = (cnt_q == '0) || (cnt_q == ONE);
  assign upd_en    = tick | wr_pulse | rd_pulse;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    expire = 1'b0;
    if (rd_pulse && rd_is_exc) begin
      run_d = 1'b0;
    end else if (wr_pulse || rd_pulse) begin
      cnt_d = reload;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      if (last_step) begin
        expire = 1'b1;
        run_d  = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  AST_EXC_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && rd_is_exc) |=> !run_q) else $error("exception read left timer running"); // R5
  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!run_q && cnt_q == '0)) else $error("timer kept running after expiry"); // R6
  AST_LOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && !(rd_pulse && rd_is_exc)) |=> (run_q && cnt_q == $past(reload))) else $error("write did not load timer"); // R6
endmodule

// File: rtl/idle_episode.sv
module idle_episode (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic fifo_empty,
  input  logic enable,
  input  logic wr_pulse,
  output logic post
);
  logic fired_q, fired_d;

  assign post = expire & fifo_empty & enable & ~fired_q;

  always_comb begin
    fired_d = fired_q;
    if (wr_pulse)  fired_d = 1'b0;
    else if (post) fired_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_q <= 1'b0;
    else        fired_q <= fired_d;
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    post |=> (fired_q || $past(wr_pulse))) else $error("post did not arm one-shot"); // R4
  AST_POST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    post |-> (fifo_empty && enable)) else $error("post without empty FIFO or enable"); // R1
endmodule

// File: rtl/idle_req.sv
module idle_req
  import idle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic              enable,
  input  logic              ack,
  output logic              req,
  output logic [STAT_W-1:0] req_status
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (post)                 req_d = 1'b1;
    else if (!enable || ack)  req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req        = req_q;
  assign req_status = req_q ? ST_IDLE_TMO : ST_NONE;

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !post) |=> !req_q) else $error("ack did not drop request"); // R7
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !req_q) else $error("request survived disable"); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack && enable) |=> req_q) else $error("request dropped without ack"); // R7
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import idle_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fifo_empty,
  input  logic              wr_pulse,
  input  logic              rd_pulse,
  input  logic              rd_is_exc,
  input  logic              enable,
  input  logic [CNT_W-1:0]  reload,
  input  logic              ack,
  output logic              req,
  output logic [STAT_W-1:0] req_status
);
  logic rst_sync_n;
  logic expire;
  logic post;

  idle_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .wr_pulse  (wr_pulse),
    .rd_pulse  (rd_pulse),
    .rd_is_exc (rd_is_exc),
    .reload    (reload),
    .expire    (expire)
  );

  idle_episode u_episode (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .expire     (expire),
    .fifo_empty (fifo_empty),
    .enable     (enable),
    .wr_pulse   (wr_pulse),
    .post       (post)
  );

  idle_req u_req (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .post       (post),
    .enable     (enable),
    .ack        (ack),
    .req        (req),
    .req_status (req_status)
  );

  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req |-> (req_status == ST_IDLE_TMO)) else $error("status code wrong while pending"); // R3
  AST_ROSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(req) |-> ($past(fifo_empty) && $past(enable))) else $error("request rose without empty FIFO"); // R1
endmodule

// File: tb/tb_rx_idle_timeout.sv
module tb_rx_idle_timeout;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk, rst_n, tick, fifo_empty, wr_pulse, rd_pulse, rd_is_exc, enable, ack;
  logic [CNT_W-1:0] reload;
  logic req;
  logic [2:0] req_status;

  int total = 0;
  int bad = 0;
  bit done = 0;

  rx_idle_timeout #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_empty(fifo_empty),
    .wr_pulse(wr_pulse), .rd_pulse(rd_pulse), .rd_is_exc(rd_is_exc),
    .enable(enable), .reload(reload), .ack(ack),
    .req(req), .req_status(req_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_req(input string tag, input int exp);
    check(tag, int'(req), exp);
    check({tag, " status"}, int'(req_status), exp ? 4 : 0); // R3 code 3'b100
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_wr();
    fifo_empty = 1'b0; wr_pulse = 1'b1; cyc(1); wr_pulse = 1'b0;
  endtask

  task automatic do_rd(input logic exc, input logic empty_after);
    rd_pulse = 1'b1; rd_is_exc = exc; cyc(1);
    rd_pulse = 1'b0; rd_is_exc = 1'b0; fifo_empty = empty_after;
  endtask

  task automatic do_tick();
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 0; fifo_empty = 1; wr_pulse = 0; rd_pulse = 0;
    rd_is_exc = 0; enable = 1; reload = 8'd3; ack = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    check_req("R9 reset", 0);
    for (int i = 0; i < 6; i++) do_tick();
    check_req("R9 idle ticks", 0);

    // R6: reload sweep, request appears exactly after tick max(reload,1)
    for (int r = 0; r <= 5; r++) begin
      int n;
      n = (r == 0) ? 1 : r;
      reload = CNT_W'(r);
      do_wr();
      do_rd(1'b0, 1'b1);
      for (int k = 1; k <= n; k++) begin
        do_tick();
        check_req($sformatf("R6 reload=%0d tick=%0d", r, k), (k == n) ? 1 : 0);
      end
      do_ack();
      cyc(1);
      check_req("R7 ack clears", 0);
    end

    // R6: restart mid-count
    reload = 8'd4;
    do_wr(); do_rd(1'b0, 1'b1);
    do_tick(); do_tick();
    do_rd(1'b0, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      do_tick();
      check_req($sformatf("R6 restart tick=%0d", k), (k == 4) ? 1 : 0);
    end
    do_ack(); cyc(1);

    // R1 R2 R5: exhaustive over enable x empty-at-expiry x exception read
    reload = 8'd2;
    for (int c = 0; c < 8; c++) begin
      logic en_c, emp_c, exc_c;
      int exp;
      en_c = c[0]; emp_c = c[1]; exc_c = c[2];
      enable = 1'b1;
      do_wr();
      do_rd(exc_c, emp_c);
      enable = en_c;
      do_tick(); do_tick(); do_tick();
      exp = (en_c && emp_c && !exc_c) ? 1 : 0;
      check_req($sformatf("R1/R2/R5 en=%0d empty=%0d exc=%0d", en_c, emp_c, exc_c), exp);
      enable = 1'b1;
      do_ack(); cyc(1);
      fifo_empty = 1'b1;
    end

    // R5: exception read while timer mid-count stops it
    reload = 8'd3;
    do_wr(); do_rd(1'b0, 1'b0); do_tick();
    do_rd(1'b1, 1'b1);
    for (int k = 0; k < 5; k++) do_tick();
    check_req("R5 exc halts running timer", 0);

    // R4: one-shot per empty episode
    reload = 8'd2;
    do_wr(); do_rd(1'b0, 1'b1);
    do_tick(); do_tick();
    check_req("R4 first expiry", 1);
    do_ack(); cyc(1);
    do_rd(1'b0, 1'b1);
    do_tick(); do_tick(); do_tick();
    check_req("R4 second expiry swallowed", 0);
    do_wr(); do_rd(1'b0, 1'b1);
    do_tick(); do_tick();
    check_req("R4 rearmed by write", 1);

    // R7: held until ack
    cyc(10);
    check_req("R7 held", 1);
    do_ack();
    check_req("R7 drop after ack", 0);

    // R8: enable clear removes pending request
    do_wr(); do_rd(1'b0, 1'b1);
    do_tick(); do_tick();
    check_req("R8 pending", 1);
    enable = 1'b0; cyc(1);
    check_req("R8 removed", 0);
    enable = 1'b1; cyc(2);
    check_req("R8 stays removed", 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule